// File: doc/BRIEF.md
# Multi-Mode Capture Timer/Counter

This block is a 16-bit counter that can act as two independent 8-bit halves or as one 16-bit unit. A 2-bit mode register picks the arrangement: two prescaled 8-bit timers, a prescaled 8-bit timer next to an 8-bit event counter, one prescaled 16-bit timer, or one 16-bit event counter. The prescaled timers advance on a shared divided tick. The event counters advance on rising edges of an external input, which is first brought into the clock domain.

Each counter, or each half, returns to zero when it reaches its programmed match value and raises a sticky flag. Software clears the flag by writing 1 to it. An interrupt request is raised while any flag whose enable is set is high. A capture strobe copies the whole count into a 16-bit capture register at one instant. In the split modes, the low byte of that register holds the low half and the high byte holds the high half. The prescaler tick is also brought out so that neighbouring timers can use it.

Top module: `cap_timer`

## Requirements
- R1: After a synchronous active-low reset, cap_val, match_flag, irq and pre_tick are all 0, the mode is 0 and the run bit is clear.
- R2: While the run bit is set, the prescaler counts system clocks and pre_tick is high for one cycle in every (reload+1) cycles. It is high every cycle when reload is 0, and low while run is clear.
- R3: Mode 0 runs two 8-bit timers. The low half is count[7:0] and the high half is count[15:8], and each advances by one at every pre_tick.
- R4: Mode 1 keeps the low half as a pre_tick timer, and the high half counts rising edges of evt_in. The input passes two synchronizing flops, so an edge shows up in the count on the third clock edge after it appears.
- R5: Mode 2 runs one 16-bit timer that advances on pre_tick. Mode 3 runs one 16-bit counter that advances on synchronized evt_in rising edges, without the prescaler.
- R6: When a counter or half advances while it equals its match value, it becomes 0 instead and sets its sticky flag. In the split modes, match_flag[0] belongs to the low half and match_flag[1] to the high half; in the 16-bit modes only match_flag[0] is used. Writing 1 to a flag clears it, and a new match in the same cycle wins over the clear.
- R7: When cap_strobe is high at a clock edge, cap_val takes the 16-bit count from before that edge. Both halves are captured at that same edge.
- R8: irq equals the OR of match_flag[0] AND enable0 with match_flag[1] AND enable1.
- R9: A mode write with a value different from the current mode clears the count and the prescaler at that edge. A write of the same mode leaves both unchanged.
- R10: While the run bit is clear, neither the count nor the prescaler moves. Capture still works.
- R11: Register writes use wr_en, wr_addr and wr_data. Address 0 sets the mode from data[1:0]. Address 1 sets the prescaler reload from data[7:0]. Address 2 sets the match value from data[15:0]: the low byte is the low-half match and the high byte is the high-half match. Address 3 holds the control bits: bit0 is run, bit1 is enable0 and bit2 is enable1. Address 4 clears flags: data[1:0] is written 1 to clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| evt_in | input | 1 | External event input, asynchronous |
| cap_strobe | input | 1 | Capture request |
| cap_val | output | 16 | Captured count |
| match_flag | output | 2 | Sticky match flags |
| irq | output | 1 | Interrupt request |
| pre_tick | output | 1 | Prescaler tick, one cycle wide |

## Verification
Each of the four modes runs with its own reload and match values. The bench strobes captures at random and drives evt_in with random toggles. This separates halves that advance on the tick from halves that advance on edges, and it exposes a carry or wrap that crosses between the halves by mistake. Some phases hold the run bit clear or rewrite the same mode; these show the counter frozen where a wrong design would move it or reset it. Reload 0 and a capture taken right after a mode change cover the boundary cases. Flag clears, including a clear that lands on the same cycle as a new match, are compared with a behavioural model on every cycle.

// File: rtl/cap_timer_pkg.sv
// Shared types and register addresses for the capture timer.
// Assumes a 3-bit register address space.
package cap_timer_pkg;
    typedef enum logic [1:0] {
        MODE_DUAL  = 2'd0,
        MODE_MIXED = 2'd1,
        MODE_WIDE  = 2'd2,
        MODE_EVCNT = 2'd3
    } tmode_t;

    localparam logic [2:0] ADDR_MODE   = 3'd0;
    localparam logic [2:0] ADDR_RELOAD = 3'd1;
    localparam logic [2:0] ADDR_MATCH  = 3'd2;
    localparam logic [2:0] ADDR_CTRL   = 3'd3;
    localparam logic [2:0] ADDR_FCLR   = 3'd4;
endpackage

// File: rtl/ct_prescaler.sv
// Programmable divider: emits a one-cycle tick every (reload+1) clocks
// while run is set. Assumes clr has priority over counting.
module ct_prescaler #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         clr,
    input  logic [W-1:0] reload,
    output logic         tick
);
    logic [W-1:0] pcnt_q;

    assign tick = run && (pcnt_q == reload);

    // Divider count: restart on tick or clear, hold when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) pcnt_q <= '0;
        else if (run)      pcnt_q <= tick ? '0 : pcnt_q + W'(1);
    end

    // R2: the count restarts after each tick.
    a_r2_tick_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr) |=> (pcnt_q == '0));
    // R9: a clear leaves the divider at zero.
    a_r9_pre_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pcnt_q == '0));
    // R10: a stopped divider holds still.
    a_r10_pre_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> (pcnt_q == $past(pcnt_q)));
endmodule

// File: rtl/ct_edge_sync.sv
// Brings an asynchronous level into the clock domain through STAGES
// flops and flags a rising edge for one cycle. Assumes STAGES >= 2.
module ct_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] sync_q;

    // First flop samples the raw input.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= din;
    end

    for (genvar s = 1; s <= STAGES; s++) begin : g_stage
        // Each further stage delays the one before it.
        always_ff @(posedge clk) begin
            if (!rst_n) sync_q[s] <= 1'b0;
            else        sync_q[s] <= sync_q[s-1];
        end
    end

    assign rise = sync_q[STAGES-1] && !sync_q[STAGES];

    // R4: an edge flag never lasts two cycles.
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/ct_core.sv
// Counter core: a 2*HALF_W counter that is split into two halves or run
// whole, as the mode picks. Reports a wrap pulse per half (bit 0 only in
// whole modes). Assumes tick and evt are single-cycle pulses.
module ct_core
    import cap_timer_pkg::*;
#(
    parameter int HALF_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  tmode_t                mode,
    input  logic                  run,
    input  logic                  clr,
    input  logic                  tick,
    input  logic                  evt,
    input  logic [2*HALF_W-1:0]   match,
    output logic [2*HALF_W-1:0]   cnt,
    output logic [1:0]            wrap
);
    localparam int CNT_W = 2 * HALF_W;

    logic [1:0][HALF_W-1:0] cnt_q;
    logic [1:0][HALF_W-1:0] half_nxt;
    logic [1:0][HALF_W-1:0] half_match;
    logic [1:0]             half_adv;
    logic [1:0]             half_wrap;
    logic [CNT_W-1:0]       full_nxt;
    logic                   full_adv;
    logic                   full_wrap;
    logic                   split;

    assign split       = (mode == MODE_DUAL) || (mode == MODE_MIXED);
    assign half_match  = match;
    assign half_adv[0] = run && tick;
    assign half_adv[1] = run && ((mode == MODE_DUAL) ? tick : evt);
    assign full_adv    = run && ((mode == MODE_EVCNT) ? evt : tick);

    for (genvar h = 0; h < 2; h++) begin : g_half
        // Per-half step: wrap to zero on match, else add one.
        always_comb begin
            half_wrap[h] = half_adv[h] && (cnt_q[h] == half_match[h]);
            if (half_wrap[h])     half_nxt[h] = '0;
            else if (half_adv[h]) half_nxt[h] = cnt_q[h] + HALF_W'(1);
            else                  half_nxt[h] = cnt_q[h];
        end
    end

    // Whole-width step used in the 16-bit modes.
    always_comb begin
        full_wrap = full_adv && (cnt_q == match);
        if (full_wrap)     full_nxt = '0;
        else if (full_adv) full_nxt = cnt_q + CNT_W'(1);
        else               full_nxt = cnt_q;
    end

    // Count register: clear on mode change, else take the chosen step.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt_q <= '0;
        else if (split)    cnt_q <= half_nxt;
        else               cnt_q <= full_nxt;
    end

    assign cnt  = cnt_q;
    assign wrap = clr ? 2'b00 : (split ? half_wrap : {1'b0, full_wrap});

    // R9: a mode change leaves the count at zero.
    a_r9_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
    // R6: a low-half or whole wrap leaves that part at zero.
    a_r6_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap[0] |=> (cnt[HALF_W-1:0] == '0));
    // R6: a high-half wrap leaves the high half at zero.
    a_r6_wrap_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap[1] |=> (cnt[CNT_W-1:HALF_W] == '0));
    // R10: nothing moves while stopped.
    a_r10_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/cap_timer.sv
// Multi-mode capture timer top: register file, prescaler, event
// synchronizer, counter core, capture register and sticky match flags.
// Assumes one register write per cycle; inputs other than evt_in are
// synchronous to clk.
module cap_timer
    import cap_timer_pkg::*;
#(
    parameter int HALF_W   = 8,
    parameter int PRE_W    = 8,
    parameter int SYNC_LEN = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [2:0]          wr_addr,
    input  logic [2*HALF_W-1:0] wr_data,
    input  logic                evt_in,
    input  logic                cap_strobe,
    output logic [2*HALF_W-1:0] cap_val,
    output logic [1:0]          match_flag,
    output logic                irq,
    output logic                pre_tick
);
    localparam int CNT_W = 2 * HALF_W;

    tmode_t           mode_q;
    tmode_t           mode_new;
    logic [PRE_W-1:0] reload_q;
    logic [CNT_W-1:0] match_q;
    logic             run_q;
    logic [1:0]       ie_q;
    logic [1:0]       flag_q;
    logic [1:0]       flag_clr;
    logic [CNT_W-1:0] cap_q;
    logic [CNT_W-1:0] cnt;
    logic [1:0]       wrap;
    logic             mode_clr;
    logic             evt_rise;

    assign mode_new = tmode_t'(wr_data[1:0]);
    assign mode_clr = wr_en && (wr_addr == ADDR_MODE) && (mode_new != mode_q);
    assign flag_clr = (wr_en && (wr_addr == ADDR_FCLR)) ? wr_data[1:0] : 2'b00;

    // Configuration registers written through the register port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= MODE_DUAL;
            reload_q <= '0;
            match_q  <= '0;
            run_q    <= 1'b0;
            ie_q     <= 2'b00;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_MODE:   mode_q   <= mode_new;
                ADDR_RELOAD: reload_q <= wr_data[PRE_W-1:0];
                ADDR_MATCH:  match_q  <= wr_data;
                ADDR_CTRL:   {ie_q, run_q} <= wr_data[2:0];
                default: ;
            endcase
        end
    end

    ct_prescaler #(.W(PRE_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run_q),
        .clr    (mode_clr),
        .reload (reload_q),
        .tick   (pre_tick)
    );

    ct_edge_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (evt_in),
        .rise  (evt_rise)
    );

    ct_core #(.HALF_W(HALF_W)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode_q),
        .run   (run_q),
        .clr   (mode_clr),
        .tick  (pre_tick),
        .evt   (evt_rise),
        .match (match_q),
        .cnt   (cnt),
        .wrap  (wrap)
    );

    // Capture register: snapshot the whole count on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)          cap_q <= '0;
        else if (cap_strobe) cap_q <= cnt;
    end

    // Sticky flags: write-1 clear, a new wrap wins.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 2'b00;
        else        flag_q <= (flag_q & ~flag_clr) | wrap;
    end

    assign cap_val    = cap_q;
    assign match_flag = flag_q;
    assign irq        = |(flag_q & ie_q);

    // R7: a capture holds the count from before the strobe edge.
    a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
        cap_strobe |=> (cap_val == $past(cnt)));
    // R6: a flag stays set until cleared.
    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (match_flag[0] && !flag_clr[0]) |=> match_flag[0]);
    // R6: a wrap sets its flag even against a clear.
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wrap[1] |=> match_flag[1]);
    // R8: with no flags set the request is low.
    a_r8_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (match_flag == 2'b00) |-> !irq);
endmodule

// File: tb/tb_cap_timer.sv
module tb_cap_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        evt_in = 1'b0;
    logic        cap_strobe = 1'b0;
    logic [15:0] cap_val;
    logic [1:0]  match_flag;
    logic        irq;
    logic        pre_tick;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit checking = 1'b0;
    bit done = 1'b0;
    string cur_req = "R3";

    // Behavioural model state
    int m_mode, m_reload, m_match, m_run, m_ie, m_pcnt, m_cnt, m_cap, m_flags;
    int m_s1, m_s2, m_s3;

    always #2.5 clk = ~clk;

    cap_timer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .evt_in(evt_in), .cap_strobe(cap_strobe),
        .cap_val(cap_val), .match_flag(match_flag), .irq(irq),
        .pre_tick(pre_tick)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    // Reference model, stepped at each rising edge with the inputs held there.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_mode = 0; m_reload = 0; m_match = 0; m_run = 0; m_ie = 0;
            m_pcnt = 0; m_cnt = 0; m_cap = 0; m_flags = 0;
            m_s1 = 0; m_s2 = 0; m_s3 = 0;
        end else begin
            int tk, ev, lo, hi, w, clrb;
            bit chg;
            tk = (m_run != 0 && m_pcnt == m_reload) ? 1 : 0;
            ev = (m_s2 == 1 && m_s3 == 0) ? 1 : 0;
            w = 0;
            chg = wr_en && wr_addr == 0 && int'(wr_data[1:0]) != m_mode;
            clrb = (wr_en && wr_addr == 4) ? int'(wr_data[1:0]) : 0;
            if (cap_strobe) m_cap = m_cnt;
            if (chg) begin
                m_cnt = 0; m_pcnt = 0;
            end else if (m_run != 0) begin
                m_pcnt = tk ? 0 : (m_pcnt + 1) % 256;
                if (m_mode < 2) begin
                    lo = m_cnt % 256; hi = m_cnt / 256;
                    if (tk) begin
                        if (lo == m_match % 256) begin lo = 0; w |= 1; end
                        else lo++;
                    end
                    if ((m_mode == 0) ? tk : ev) begin
                        if (hi == m_match / 256) begin hi = 0; w |= 2; end
                        else hi++;
                    end
                    m_cnt = hi * 256 + lo;
                end else if ((m_mode == 3) ? ev : tk) begin
                    if (m_cnt == m_match) begin m_cnt = 0; w |= 1; end
                    else m_cnt = (m_cnt + 1) % 65536;
                end
            end
            m_flags = (m_flags & ~clrb) | w;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_mode = int'(wr_data[1:0]);
                    3'd1: m_reload = int'(wr_data[7:0]);
                    3'd2: m_match = int'(wr_data);
                    3'd3: begin m_run = int'(wr_data[0]); m_ie = int'(wr_data[2:1]); end
                    default: ;
                endcase
            end
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(evt_in);
        end
    end

    // Compare every output with the model away from the active edge.
    always @(negedge clk) begin
        if (checking && rst_n) begin
            check(cur_req, "cap_val", int'(cap_val), m_cap);
            check("R6", "match_flag", int'(match_flag), m_flags);
            check("R8", "irq", int'(irq), ((m_flags & m_ie) != 0) ? 1 : 0);
            check("R2", "pre_tick", int'(pre_tick),
                  (m_run != 0 && m_pcnt == m_reload) ? 1 : 0);
        end
    end

    // Watchdog: a hung run counts as one failure.
    initial begin
        #(5ns * 150000);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(addr); wr_data = 16'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Random strobes and event toggles, with an occasional flag clear.
    task automatic run_cycles(input int n, input bit evts, input int clr_every);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cap_strobe = ($urandom % 10) < 3;
            if (evts) evt_in = $urandom % 2;
            if (clr_every > 0 && (i % clr_every) == clr_every - 1) begin
                wr_en = 1'b1; wr_addr = 3'd4; wr_data = 16'(i % 4);
            end else begin
                wr_en = 1'b0;
            end
        end
        @(negedge clk);
        wr_en = 1'b0; cap_strobe = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values
        check("R1", "cap_val", int'(cap_val), 0);
        check("R1", "match_flag", int'(match_flag), 0);
        check("R1", "irq", int'(irq), 0);
        check("R1", "pre_tick", int'(pre_tick), 0);
        checking = 1'b1;

        // R3 / R11: mode 0, two prescaled 8-bit timers
        cur_req = "R3";
        wr(1, 2); wr(2, 16'h0403); wr(3, 7);
        run_cycles(300, 1'b1, 23);

        // R2: reload 0 ticks every cycle
        wr(1, 0);
        @(negedge clk);
        check("R2", "pre_tick reload0", int'(pre_tick), 1);
        @(negedge clk);
        check("R2", "pre_tick reload0 next", int'(pre_tick), 1);

        // R4: mode 1, timer low and event counter high
        cur_req = "R4";
        wr(0, 1); wr(1, 1); wr(2, 16'h0605);
        run_cycles(400, 1'b1, 31);

        // R9: same-mode write keeps the count, new mode clears it
        cur_req = "R9";
        wr(0, 1);
        run_cycles(20, 1'b1, 0);
        wr(1, 3);
        wr(0, 2);
        @(negedge clk); cap_strobe = 1'b1;
        @(negedge clk); cap_strobe = 1'b0;
        check("R9", "cap after mode change", int'(cap_val), 0);

        // R5: mode 2, 16-bit prescaled timer
        cur_req = "R5";
        wr(1, 1); wr(2, 16'h0123);
        run_cycles(900, 1'b0, 97);

        // R5: mode 3, 16-bit event counter
        wr(0, 3); wr(2, 16'h0010);
        run_cycles(500, 1'b1, 41);

        // R10: stopped counter holds while captures still work
        cur_req = "R10";
        wr(3, 6);
        run_cycles(100, 1'b1, 0);
        check("R10", "pre_tick stopped", int'(pre_tick), 0);

        // R8: interrupt masked then unmasked
        wr(3, 1);
        run_cycles(60, 1'b1, 0);
        wr(3, 7);
        run_cycles(60, 1'b1, 0);

        // R7: captures in mode 0 across both halves
        cur_req = "R7";
        wr(0, 0); wr(1, 0); wr(2, 16'hFFFF);
        run_cycles(600, 1'b0, 0);

        checking = 1'b0;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule